// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits in a host bridge and steers every CPU access that falls in the legacy area between 0xA0000 and 0xFFFFF. It holds a small set of programmable attribute bytes. Thirteen shadow regions each carry a 2-bit access mode that sends the access to DRAM, sends it to the PCI bus, or blocks a write. The 128 KB system-management window at 0xA0000 is also decoded: it is backed by DRAM only when a control byte opens it, either unconditionally or while the CPU is in system-management mode.

Configuration arrives one byte at a time through a write port that carries an offset. Every cycle, one CPU access (address, write flag, SMM level) is decoded. One clock later exactly one of four result flags is high: DRAM, PCI, write blocked, or pass-through for addresses the block does not decode. A configuration write in cycle N applies to the access presented in cycle N+1. A change on the SMM input applies to the access that comes with it.

Top module: `legacy_mem_decoder`

## Requirements
- R1: While reset is held the result is pass-through only. After reset every attribute byte is 0x00 and the management control byte is 0x02, so all shadow regions and the 0xA0000 window resolve to PCI, even with SMM asserted.
- R2: Bits [5:4] of the attribute byte at offset 0x59 hold the mode of the 64 KB region 0xF0000-0xFFFFF.
- R3: Offsets 0x5A-0x5F hold the modes of twelve 16 KB regions starting at 0xC0000. Region k (0..11) uses byte 0x5A+(k>>1): even k uses bits [1:0] and odd k uses bits [5:4].
- R4: Mode 3 resolves both reads and writes to DRAM.
- R5: Mode 1 resolves reads to DRAM. A write in mode 1 raises only the write-blocked flag; neither the DRAM nor the PCI flag is raised.
- R6: Modes 0 and 2 resolve reads and writes to PCI.
- R7: When bit 6 of the management control byte (offset 0x72) is set, the window 0xA0000-0xBFFFF resolves to DRAM for reads and writes, whatever the SMM input.
- R8: When bit 6 is clear, the window resolves to DRAM only if bit 3 is set and the SMM input is high in the same cycle as the access. Otherwise it resolves to PCI.
- R9: A configuration write to offsets 0x59-0x5F or 0x72 governs the access presented in the next cycle. Writes to any other offset change no routing.
- R10: Addresses below 0xA0000 or at 0x100000 and above give the pass-through flag only.
- R11: Results are registered and appear one clock after the access. Exactly one of the four result flags is high at any time out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | OFF_W (8) | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | ADDR_W (32) | CPU access address |
| acc_wr | input | 1 | 1 = write access, 0 = read |
| acc_smm | input | 1 | CPU is in system-management mode |
| dec_to_ram | output | 1 | Access is routed to DRAM |
| dec_to_pci | output | 1 | Access is routed to the PCI bus |
| dec_wr_blocked | output | 1 | Write to a read-only shadow region was dropped |
| dec_pass | output | 1 | Address is outside the decoded area |

## Verification
The bench cannot see the stored attribute bytes. A corrupted or misplaced mode field shows up as a wrong result flag on the first access that lands in the affected 16 KB or 64 KB region, one clock after that access. A write that lands on the wrong offset is caught by probing the neighbouring region and both boundary addresses of every programmed region. A wrong window-control state, or SMM being sampled late, shows up on the next window access: the bench toggles SMM between consecutive accesses to catch a one-cycle lag.

// File: rtl/lmad_pkg.sv
package lmad_pkg;

    // 2-bit shadow region access mode
    typedef enum logic [1:0] {
        MODE_PCI_A = 2'd0,
        MODE_RD_ONLY = 2'd1,
        MODE_PCI_B = 2'd2,
        MODE_RD_WR = 2'd3
    } pam_mode_e;

    typedef enum logic [1:0] {
        ZONE_NONE  = 2'd0,
        ZONE_SMWIN = 2'd1,
        ZONE_PAM   = 2'd2
    } zone_e;

    typedef struct packed {
        logic to_ram;
        logic to_pci;
        logic wr_blocked;
        logic pass;
    } route_t;

    localparam route_t ROUTE_IDLE = '{to_ram: 1'b0, to_pci: 1'b0, wr_blocked: 1'b0, pass: 1'b1};

    // address map of the decoded area (in 64 KB segments / 16 KB blocks)
    localparam logic [3:0] SEG_SMWIN_LO = 4'hA;
    localparam logic [3:0] SEG_SMWIN_HI = 4'hB;
    localparam logic [3:0] SEG_PAM_LO   = 4'hC;
    localparam logic [3:0] SEG_TOP      = 4'hF;
    localparam logic [5:0] BLK_PAM_BASE = 6'h30;

    // management control byte fields
    localparam int SMW_OPEN_BIT = 6;
    localparam int SMW_EN_BIT   = 3;

endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs #(
    parameter int         OFF_W      = 8,
    parameter int         NUM_BYTES  = 7,
    parameter logic [7:0] PAM_BASE   = 8'h59,
    parameter logic [7:0] SMW_OFF    = 8'h72,
    parameter logic [7:0] SMW_RST    = 8'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [OFF_W-1:0]            cfg_off,
    input  logic [7:0]                  cfg_wdata,
    output logic [NUM_BYTES-1:0][7:0]   pam_bytes,
    output logic [7:0]                  smw_byte
);

    typedef struct packed {
        logic [NUM_BYTES-1:0][7:0] pam;
        logic [7:0]                smw;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (cfg_off == OFF_W'(int'(PAM_BASE) + i)) begin
                    st_d.pam[i] = cfg_wdata;
                end
            end
            if (cfg_off == OFF_W'(SMW_OFF)) begin
                st_d.smw = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pam <= '0;
            st_q.smw <= SMW_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pam_bytes = st_q.pam;
    assign smw_byte  = st_q.smw;

    AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_off) < int'(PAM_BASE) || int'(cfg_off) >= int'(PAM_BASE) + NUM_BYTES)
                && cfg_off != OFF_W'(SMW_OFF)) |=> $stable(st_q)); // R9

endmodule

// File: rtl/lmad_region_sel.sv
module lmad_region_sel
    import lmad_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_LOW_REG = 12,
    localparam int NUM_BYTES  = 1 + (NUM_LOW_REG + 1) / 2,
    localparam int NUM_REG    = NUM_LOW_REG + 1,
    localparam int IDX_W      = $clog2(NUM_REG)
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES-1:0][7:0]   pam_bytes,
    output zone_e                       zone,
    output pam_mode_e                   mode
);

    logic [NUM_REG-1:0][1:0] mode_tab;

    // region 0 is the top 64 KB segment, regions 1.. are the 16 KB blocks
    assign mode_tab[0] = pam_bytes[0][5:4];

    generate
        for (genvar k = 0; k < NUM_LOW_REG; k++) begin : g_low
            assign mode_tab[k+1] = pam_bytes[1 + k/2][(k%2)*4 +: 2];
        end
    endgenerate

    logic             hi_zero;
    logic [3:0]       seg;
    logic [5:0]       blk_off;
    logic [IDX_W-1:0] reg_idx;

    always_comb begin
        hi_zero = (addr[ADDR_W-1:20] == '0);
        seg     = addr[19:16];
        blk_off = addr[19:14] - BLK_PAM_BASE;
        reg_idx = (seg == SEG_TOP) ? '0 : IDX_W'(blk_off + 6'd1);

        zone = ZONE_NONE;
        mode = MODE_PCI_A;
        if (hi_zero) begin
            if (seg == SEG_SMWIN_LO || seg == SEG_SMWIN_HI) begin
                zone = ZONE_SMWIN;
            end else if (seg >= SEG_PAM_LO) begin
                zone = ZONE_PAM;
                if (int'(reg_idx) < NUM_REG) begin
                    mode = pam_mode_e'(mode_tab[reg_idx]);
                end
            end
        end
    end

endmodule

// File: rtl/lmad_route.sv
module lmad_route
    import lmad_pkg::*;
(
    input  zone_e       zone,
    input  pam_mode_e   mode,
    input  logic        acc_wr,
    input  logic        acc_smm,
    input  logic [7:0]  smw_byte,
    output route_t      route
);

    always_comb begin
        route = '0;
        unique case (zone)
            ZONE_SMWIN: begin
                if (smw_byte[SMW_OPEN_BIT] || (acc_smm && smw_byte[SMW_EN_BIT])) begin
                    route.to_ram = 1'b1;
                end else begin
                    route.to_pci = 1'b1;
                end
            end
            ZONE_PAM: begin
                unique case (mode)
                    MODE_RD_WR:   route.to_ram = 1'b1;
                    MODE_RD_ONLY: begin
                        if (acc_wr) route.wr_blocked = 1'b1;
                        else        route.to_ram     = 1'b1;
                    end
                    default:      route.to_pci = 1'b1;
                endcase
            end
            default: route.pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lmad_pkg::*;
#(
    parameter int         ADDR_W      = 32,
    parameter int         OFF_W       = 8,
    parameter int         NUM_LOW_REG = 12,
    parameter logic [7:0] PAM_BASE    = 8'h59,
    parameter logic [7:0] SMW_OFF     = 8'h72,
    parameter logic [7:0] SMW_RST     = 8'h02,
    localparam int        NUM_BYTES   = 1 + (NUM_LOW_REG + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              acc_smm,
    output logic              dec_to_ram,
    output logic              dec_to_pci,
    output logic              dec_wr_blocked,
    output logic              dec_pass
);

    logic [NUM_BYTES-1:0][7:0] pam_bytes;
    logic [7:0]                smw_byte;
    zone_e                     zone;
    pam_mode_e                 mode;
    route_t                    dec_d, dec_q;

    lmad_cfg_regs #(
        .OFF_W     (OFF_W),
        .NUM_BYTES (NUM_BYTES),
        .PAM_BASE  (PAM_BASE),
        .SMW_OFF   (SMW_OFF),
        .SMW_RST   (SMW_RST)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_off   (cfg_off),
        .cfg_wdata (cfg_wdata),
        .pam_bytes (pam_bytes),
        .smw_byte  (smw_byte)
    );

    lmad_region_sel #(
        .ADDR_W      (ADDR_W),
        .NUM_LOW_REG (NUM_LOW_REG)
    ) i_sel (
        .addr      (acc_addr),
        .pam_bytes (pam_bytes),
        .zone      (zone),
        .mode      (mode)
    );

    lmad_route i_route (
        .zone     (zone),
        .mode     (mode),
        .acc_wr   (acc_wr),
        .acc_smm  (acc_smm),
        .smw_byte (smw_byte),
        .route    (dec_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= ROUTE_IDLE;
        else        dec_q <= dec_d;
    end

    assign dec_to_ram     = dec_q.to_ram;
    assign dec_to_pci     = dec_q.to_pci;
    assign dec_wr_blocked = dec_q.wr_blocked;
    assign dec_pass       = dec_q.pass;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dec_to_ram, dec_to_pci, dec_wr_blocked, dec_pass}) == 1); // R11

    AST_BLOCK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr_blocked |-> $past(acc_wr)); // R5

    AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_pass && $past(rst_n)) |->
            ($past(acc_addr) < ADDR_W'(32'hA0000) || $past(acc_addr) >= ADDR_W'(32'h100000))); // R10

    AST_SMWIN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_addr[ADDR_W-1:17]) == (ADDR_W-17)'(5)
            && !$past(smw_byte[SMW_OPEN_BIT]) && !$past(acc_smm)) |-> !dec_to_ram); // R8

endmodule

// File: tb/test_legacy_mem_decoder.sv
module test_legacy_mem_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    localparam logic [1:0] E_RAM = 2'd0;
    localparam logic [1:0] E_PCI = 2'd1;
    localparam logic [1:0] E_BLK = 2'd2;
    localparam logic [1:0] E_PAS = 2'd3;

    typedef struct {
        logic [1:0]  code;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        acc_smm = 1'b0;
    logic        dec_to_ram, dec_to_pci, dec_wr_blocked, dec_pass;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_mem_decoder i_legacy_mem_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_off        (cfg_off),
        .cfg_wdata      (cfg_wdata),
        .acc_addr       (acc_addr),
        .acc_wr         (acc_wr),
        .acc_smm        (acc_smm),
        .dec_to_ram     (dec_to_ram),
        .dec_to_pci     (dec_to_pci),
        .dec_wr_blocked (dec_wr_blocked),
        .dec_pass       (dec_pass)
    );

    function automatic logic [3:0] flags(logic [1:0] code);
        case (code)
            E_RAM:   return 4'b1000;
            E_PCI:   return 4'b0100;
            E_BLK:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_off = off;
        cfg_wdata = data;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    // driver: present one access, push the expected result for the monitor
    task automatic access(input logic [31:0] a, input logic wr, input logic smm,
                          input logic [1:0] code, input string tag);
        exp_t e;
        @(negedge clk);
        acc_addr = a;
        acc_wr = wr;
        acc_smm = smm;
        e.code = code;
        e.addr = a;
        e.tag = tag;
        @(posedge clk);
        sb_q.push_back(e);
    endtask

    // monitor: result is registered one clock after the access (R11)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [3:0] act;
                e = sb_q.pop_front();
                act = {dec_to_ram, dec_to_pci, dec_wr_blocked, dec_pass};
                total++;
                if (act !== flags(e.code)) begin
                    bad++;
                    $display("FAIL %s R11 addr=%h actual=%b expected=%b", e.tag, e.addr, act, flags(e.code));
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset output state
        repeat (3) @(negedge clk);
        total++;
        if ({dec_to_ram, dec_to_pci, dec_wr_blocked, dec_pass} !== 4'b0001) begin
            bad++;
            $display("FAIL R1 reset actual=%b expected=%b",
                     {dec_to_ram, dec_to_pci, dec_wr_blocked, dec_pass}, 4'b0001);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: defaults route to PCI
        access(32'h000C0000, 1'b0, 1'b0, E_PCI, "R1 low region default");
        access(32'h000F8000, 1'b1, 1'b0, E_PCI, "R1 top region default");
        access(32'h000A0000, 1'b0, 1'b1, E_PCI, "R1 window default with smm");

        // R2 / R4: top segment mode 3
        cfg_write(8'h59, 8'h30);
        access(32'h000F0000, 1'b0, 1'b0, E_RAM, "R2 R4 top read");
        access(32'h000FFFFF, 1'b1, 1'b0, E_RAM, "R2 R4 top write");
        access(32'h000EFFFF, 1'b0, 1'b0, E_PCI, "R3 region below top untouched");

        // R5: top segment mode 1
        cfg_write(8'h59, 8'h10);
        access(32'h000F0000, 1'b1, 1'b0, E_BLK, "R5 top write blocked");
        access(32'h000F4000, 1'b0, 1'b0, E_RAM, "R5 top read");

        // R6: top segment mode 2
        cfg_write(8'h59, 8'h20);
        access(32'h000F0000, 1'b0, 1'b0, E_PCI, "R6 mode2 read");
        access(32'h000F0000, 1'b1, 1'b0, E_PCI, "R6 mode2 write");

        // R3: byte 0x5A, even region bits[1:0]=1, odd region bits[5:4]=3
        cfg_write(8'h5A, 8'h31);
        access(32'h000C3FFF, 1'b0, 1'b0, E_RAM, "R3 R5 region0 read");
        access(32'h000C3FFF, 1'b1, 1'b0, E_BLK, "R3 R5 region0 write");
        access(32'h000C4000, 1'b1, 1'b0, E_RAM, "R3 R4 region1 write");
        access(32'h000C8000, 1'b0, 1'b0, E_PCI, "R3 region2 untouched");

        // R3: byte 0x5F, region 10 mode 3, region 11 mode 0
        cfg_write(8'h5F, 8'h03);
        access(32'h000E8000, 1'b1, 1'b0, E_RAM, "R3 region10 write");
        access(32'h000EBFFF, 1'b0, 1'b0, E_RAM, "R3 region10 end");
        access(32'h000EC000, 1'b0, 1'b0, E_PCI, "R3 R6 region11");

        // R9: writes to other offsets ignored
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h71, 8'hFF);
        cfg_write(8'h73, 8'hFF);
        access(32'h000EC000, 1'b0, 1'b0, E_PCI, "R9 region11 after stray writes");
        access(32'h000C8000, 1'b1, 1'b0, E_PCI, "R9 region2 after stray writes");
        access(32'h000A0000, 1'b0, 1'b1, E_PCI, "R9 window after stray writes");
        access(32'h000F0000, 1'b0, 1'b0, E_PCI, "R9 top after stray writes");

        // R8: SMM-gated window, SMM toggled access by access
        cfg_write(8'h72, 8'h0A);
        access(32'h000A0000, 1'b0, 1'b0, E_PCI, "R8 window no smm");
        access(32'h000BFFFF, 1'b1, 1'b1, E_RAM, "R8 window smm");
        access(32'h000A8000, 1'b0, 1'b0, E_PCI, "R8 window smm dropped");
        access(32'h000B0000, 1'b0, 1'b1, E_RAM, "R8 window smm again");

        // R7: window forced open
        cfg_write(8'h72, 8'h42);
        access(32'h000A0000, 1'b0, 1'b0, E_RAM, "R7 open read");
        access(32'h000BFFFF, 1'b1, 1'b0, E_RAM, "R7 open write");

        // R10: pass-through outside decoded area
        access(32'h0009FFFF, 1'b0, 1'b0, E_PAS, "R10 below window");
        access(32'h00100000, 1'b1, 1'b1, E_PAS, "R10 above 1MB");
        access(32'h000F0000 | 32'h01000000, 1'b0, 1'b0, E_PAS, "R10 high alias");
        access(32'h00000000, 1'b0, 1'b0, E_PAS, "R10 zero");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule